// File: doc/BRIEF.md
# Split Two-Way Translation Cache

This block holds recently used virtual-to-physical page translations so that most accesses skip a page-table walk. It keeps two independent arrays, one serving instruction fetches and one serving data accesses. Each array has a parameterised number of sets (64 by default) with two ways per set. Each entry holds a page tag, a physical page base, a 32-bit copy of the second word of the page-table entry it came from, a most-recent flag and an invalid flag.

A lookup is answered in the same cycle: hit or miss, plus the physical address. Changes to the flags and to the stored word take effect at the next clock edge. After an external walk the surrounding logic writes the result through the refill port. A write to a page whose stored changed bit is clear is turned into a miss, so that the external walker goes back and marks the page in memory. The invalidate port clears a whole set in both arrays at once. Page walks, exceptions and memory traffic all live outside the block.

Top module: `split_xlat_cache`

## Requirements
- R1: The access kind is encoded as 0 read, 1 write, 2 fetch and 3 probe. Kind 2 uses the instruction array. Kinds 0, 1 and 3 use the data array. An entry in one array never produces a hit for the other array.
- R2: The set is chosen by virtual address bits [17:12] and the tag is virtual address bits [31:12]. A way hits when its tag matches and it is valid. On a hit, `lk_paddr` is the stored page base with virtual bits [11:0] placed in its low 12 bits.
- R3: On a write lookup that matches a way whose stored word has the changed bit (bit 7) clear, the block reports a miss and sets bit 7 in the stored copy. It leaves the most-recent flags unchanged. Repeating the same write in the next cycle then hits.
- R4: A hit that is not a probe makes the hitting way most-recent and clears the other way's flag. A probe hit leaves both flags as they were.
- R5: A refill writes way 0 when way 0 is invalid or not most-recent, and writes way 1 otherwise. The written way becomes valid and most-recent, and the other way loses its most-recent flag. The stored page base is the refill page number shifted left by 12.
- R6: A refill whose kind is probe (3) has no effect.
- R7: An invalidate makes both ways of the set given by its address bits [17:12] invalid in both arrays, whatever their tags. Other sets are not affected.
- R8: During and after reset every entry of both arrays is invalid, so every lookup misses.
- R9: When a refill and a lookup address the same set of the same array in the same cycle, the lookup's update to flags and stored word is dropped.
- R10: When an invalidate and a refill address the same set in the same cycle, the set is left invalid.
- R11: When `lk_valid` is low, `lk_hit` is 0 and `lk_paddr` is 0. On any miss, `lk_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_kind | input | 2 | Lookup access kind (0 read, 1 write, 2 fetch, 3 probe) |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Translation found and usable |
| lk_paddr | output | 32 | Translated physical address, 0 on miss |
| rf_valid | input | 1 | Refill request this cycle |
| rf_kind | input | 2 | Access kind that caused the walk |
| rf_vaddr | input | 32 | Virtual address that was walked |
| rf_ppn | input | 20 | Physical page number from the walk |
| rf_pte2 | input | 32 | Second page-table word to keep with the entry |
| inv_valid | input | 1 | Invalidate request this cycle |
| inv_vaddr | input | 32 | Address whose set is cleared |

## Verification
The hardest states to reach are those where the replacement flags have to be observed, because the ports never show them directly. The only way to see them is through which way a later refill evicts. The stimulus therefore fills a set with two pages and then steers the most-recent flag with reads, probes or changed-bit misses. It then refills a third page and checks which of the two older pages still hits. The same-cycle collisions (refill against lookup, and invalidate against refill) are driven as directed cycles. For the first of these, the changed-bit miss is used: if the dropped update had been kept, the following write would hit.

// File: rtl/split_xlat_cache.sv
module split_xlat_cache #(
  parameter int SETS  = 64,
  parameter int VA_W  = 32,
  parameter int PG_SH = 12,
  parameter int C_BIT = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [1:0]            lk_kind,
  input  logic [VA_W-1:0]       lk_vaddr,
  output logic                  lk_hit,
  output logic [VA_W-1:0]       lk_paddr,
  input  logic                  rf_valid,
  input  logic [1:0]            rf_kind,
  input  logic [VA_W-1:0]       rf_vaddr,
  input  logic [VA_W-PG_SH-1:0] rf_ppn,
  input  logic [31:0]           rf_pte2,
  input  logic                  inv_valid,
  input  logic [VA_W-1:0]       inv_vaddr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VA_W - PG_SH;
  localparam int IX_HI = PG_SH + IDX_W - 1;
  localparam logic [1:0] K_WR = 2'd1, K_IF = 2'd2, K_PR = 2'd3;

  logic [TAG_W-1:0] tag_q  [2][SETS][2];
  logic [TAG_W-1:0] base_q [2][SETS][2];
  logic [31:0]      pte_q  [2][SETS][2];
  logic             mru_q  [2][SETS][2];
  logic             inv_q  [2][SETS][2];

  logic             lk_arr, rf_arr, lk_way, rf_way, lk_any, lk_cfix;
  logic             rf_go, rf_wr, lk_go;
  logic [IDX_W-1:0] lk_set, rf_set, iv_set;
  logic [TAG_W-1:0] lk_tag;
  logic [1:0]       way_hit;
  logic [31:0]      lk_pte;
  logic             unused_bits;

  assign lk_arr = (lk_kind == K_IF);
  assign rf_arr = (rf_kind == K_IF);
  assign lk_set = lk_vaddr[IX_HI:PG_SH];
  assign rf_set = rf_vaddr[IX_HI:PG_SH];
  assign iv_set = inv_vaddr[IX_HI:PG_SH];
  assign lk_tag = lk_vaddr[VA_W-1:PG_SH];
  assign unused_bits = ^{rf_vaddr[PG_SH-1:0], inv_vaddr[VA_W-1:IX_HI+1], inv_vaddr[PG_SH-1:0]};

  always_comb begin
    for (int w = 0; w < 2; w++)
      way_hit[w] = (tag_q[lk_arr][lk_set][w] == lk_tag) && !inv_q[lk_arr][lk_set][w];
  end

  assign lk_any   = |way_hit;
  assign lk_way   = !way_hit[0];
  assign lk_pte   = pte_q[lk_arr][lk_set][lk_way];
  assign lk_cfix  = lk_valid && lk_any && (lk_kind == K_WR) && !lk_pte[C_BIT];
  assign lk_hit   = lk_valid && lk_any && !lk_cfix;
  assign lk_paddr = lk_hit ? {base_q[lk_arr][lk_set][lk_way], lk_vaddr[PG_SH-1:0]} : '0;

  assign rf_go  = rf_valid && (rf_kind != K_PR);
  assign rf_way = mru_q[rf_arr][rf_set][0] && !inv_q[rf_arr][rf_set][0];
  assign rf_wr  = rf_go && !(inv_valid && iv_set == rf_set);
  assign lk_go  = lk_valid && lk_any && (lk_kind != K_PR)
                  && !(rf_go && rf_arr == lk_arr && rf_set == lk_set)
                  && !(inv_valid && iv_set == lk_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 2; a++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < 2; w++) begin
            tag_q[a][s][w]  <= '0;
            base_q[a][s][w] <= '0;
            pte_q[a][s][w]  <= '0;
            mru_q[a][s][w]  <= 1'b0;
            inv_q[a][s][w]  <= 1'b1;
          end
    end else begin
      if (lk_go) begin
        if (lk_cfix)
          pte_q[lk_arr][lk_set][lk_way][C_BIT] <= 1'b1;
        else begin
          mru_q[lk_arr][lk_set][lk_way]  <= 1'b1;
          mru_q[lk_arr][lk_set][!lk_way] <= 1'b0;
        end
      end
      if (rf_wr) begin
        tag_q[rf_arr][rf_set][rf_way]  <= rf_vaddr[VA_W-1:PG_SH];
        base_q[rf_arr][rf_set][rf_way] <= rf_ppn;
        pte_q[rf_arr][rf_set][rf_way]  <= rf_pte2;
        mru_q[rf_arr][rf_set][rf_way]  <= 1'b1;
        inv_q[rf_arr][rf_set][rf_way]  <= 1'b0;
        mru_q[rf_arr][rf_set][!rf_way] <= 1'b0;
      end
      if (inv_valid) begin
        for (int a = 0; a < 2; a++)
          for (int w = 0; w < 2; w++)
            inv_q[a][iv_set][w] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/split_xlat_cache_chk.sv
module split_xlat_cache_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [1:0]      lk_kind,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_hit,
  input logic [VA_W-1:0] lk_paddr,
  input logic            rf_valid,
  input logic [1:0]      rf_kind,
  input logic [VA_W-1:0] rf_vaddr,
  input logic            inv_valid,
  input logic [VA_W-1:0] inv_vaddr,
  input logic            lk_cfix
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_paddr == '0));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[11:0] == lk_vaddr[11:0]);

  assert_cbit_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_cfix && !rf_valid && !inv_valid) && lk_valid && lk_kind == 2'd1
     && lk_vaddr == $past(lk_vaddr)) |-> lk_hit);

  assert_set_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_valid) && lk_valid && lk_vaddr[17:12] == $past(inv_vaddr[17:12])) |-> !lk_hit);

  assert_refill_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rf_valid && rf_kind == 2'd0 && !inv_valid) && lk_valid && lk_kind == 2'd0
     && lk_vaddr[31:12] == $past(rf_vaddr[31:12])) |-> lk_hit);

  assert_reset_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);
endmodule

bind split_xlat_cache split_xlat_cache_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_kind(lk_kind),
  .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
  .rf_valid(rf_valid), .rf_kind(rf_kind), .rf_vaddr(rf_vaddr),
  .inv_valid(inv_valid), .inv_vaddr(inv_vaddr), .lk_cfix(lk_cfix)
);

// File: tb/sim_split_xlat_cache.sv
`timescale 1ns/1ps
module sim_split_xlat_cache;
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  kind;
    logic [31:0] va;
    logic [19:0] ppn;
    logic [31:0] pte;
    logic        ehit;
    logic [31:0] epa;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] LK = 2'd0, RF = 2'd1, IV = 2'd2;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, IF = 2'd2, PR = 2'd3;
  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{LK, RD, 32'h00005123, 20'h0,     32'h0,  1'b0, 32'h0,        4'd8},  // R8 empty
    '{RF, RD, 32'h00005000, 20'h11111, 32'h80, 1'b0, 32'h0,        4'd5},
    '{LK, RD, 32'h00005123, 20'h0,     32'h0,  1'b1, 32'h11111123, 4'd2},  // R2
    '{LK, IF, 32'h00005123, 20'h0,     32'h0,  1'b0, 32'h0,        4'd1},  // R1
    '{RF, RD, 32'h00045000, 20'h22222, 32'h80, 1'b0, 32'h0,        4'd5},
    '{LK, RD, 32'h00045abc, 20'h0,     32'h0,  1'b1, 32'h22222abc, 4'd5},  // R5
    '{LK, RD, 32'h00005000, 20'h0,     32'h0,  1'b1, 32'h11111000, 4'd4},  // R4
    '{RF, RD, 32'h00085000, 20'h33333, 32'h80, 1'b0, 32'h0,        4'd5},
    '{LK, RD, 32'h00045abc, 20'h0,     32'h0,  1'b0, 32'h0,        4'd5},  // R5 evicted
    '{LK, RD, 32'h00005fff, 20'h0,     32'h0,  1'b1, 32'h11111fff, 4'd5},  // R5 kept
    '{LK, RD, 32'h00085010, 20'h0,     32'h0,  1'b1, 32'h33333010, 4'd4},
    '{LK, PR, 32'h00005020, 20'h0,     32'h0,  1'b1, 32'h11111020, 4'd4},  // R4 probe
    '{RF, RD, 32'h000c5000, 20'h44444, 32'h80, 1'b0, 32'h0,        4'd5},
    '{LK, RD, 32'h00005020, 20'h0,     32'h0,  1'b0, 32'h0,        4'd4},  // R4
    '{LK, RD, 32'h00085010, 20'h0,     32'h0,  1'b1, 32'h33333010, 4'd4},
    '{LK, RD, 32'h000c5008, 20'h0,     32'h0,  1'b1, 32'h44444008, 4'd5},
    '{RF, PR, 32'h00105000, 20'h55555, 32'h80, 1'b0, 32'h0,        4'd6},
    '{LK, RD, 32'h00105000, 20'h0,     32'h0,  1'b0, 32'h0,        4'd6},  // R6
    '{LK, RD, 32'h00085010, 20'h0,     32'h0,  1'b1, 32'h33333010, 4'd6},  // R6
    '{RF, WR, 32'h00009000, 20'h66666, 32'h0,  1'b0, 32'h0,        4'd3},
    '{LK, WR, 32'h00009010, 20'h0,     32'h0,  1'b0, 32'h0,        4'd3},  // R3
    '{LK, WR, 32'h00009010, 20'h0,     32'h0,  1'b1, 32'h66666010, 4'd3},  // R3
    '{RF, RD, 32'h00049000, 20'h77777, 32'h0,  1'b0, 32'h0,        4'd5},
    '{LK, RD, 32'h00009010, 20'h0,     32'h0,  1'b1, 32'h66666010, 4'd4},
    '{LK, WR, 32'h00049020, 20'h0,     32'h0,  1'b0, 32'h0,        4'd3},  // R3
    '{RF, RD, 32'h00089000, 20'h12345, 32'h80, 1'b0, 32'h0,        4'd5},
    '{LK, RD, 32'h00009010, 20'h0,     32'h0,  1'b1, 32'h66666010, 4'd3},  // R3
    '{LK, RD, 32'h00089004, 20'h0,     32'h0,  1'b1, 32'h12345004, 4'd5},
    '{RF, IF, 32'h00003000, 20'h0abcd, 32'h80, 1'b0, 32'h0,        4'd1},
    '{LK, IF, 32'h00003004, 20'h0,     32'h0,  1'b1, 32'h0abcd004, 4'd1},  // R1
    '{LK, RD, 32'h00003004, 20'h0,     32'h0,  1'b0, 32'h0,        4'd1},  // R1
    '{IV, RD, 32'hfffc3abc, 20'h0,     32'h0,  1'b0, 32'h0,        4'd7},
    '{LK, IF, 32'h00003004, 20'h0,     32'h0,  1'b0, 32'h0,        4'd7},  // R7
    '{IV, RD, 32'hfffc5fff, 20'h0,     32'h0,  1'b0, 32'h0,        4'd7},
    '{LK, RD, 32'h00085010, 20'h0,     32'h0,  1'b0, 32'h0,        4'd7},  // R7
    '{LK, RD, 32'h000c5008, 20'h0,     32'h0,  1'b0, 32'h0,        4'd7},  // R7
    '{LK, RD, 32'h00009010, 20'h0,     32'h0,  1'b1, 32'h66666010, 4'd7}   // R7 other set
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_valid = 1'b0, rf_valid = 1'b0, inv_valid = 1'b0;
  logic [1:0]  lk_kind = '0, rf_kind = '0;
  logic [31:0] lk_vaddr = '0, rf_vaddr = '0, inv_vaddr = '0, rf_pte2 = '0;
  logic [19:0] rf_ppn = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  split_xlat_cache u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_kind(lk_kind),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .rf_valid(rf_valid), .rf_kind(rf_kind), .rf_vaddr(rf_vaddr),
    .rf_ppn(rf_ppn), .rf_pte2(rf_pte2), .inv_valid(inv_valid), .inv_vaddr(inv_vaddr)
  );

  task automatic check(input int req, input logic eh, input logic [31:0] epa);
    n_chk++;
    if (lk_hit !== eh || lk_paddr !== epa) begin
      n_bad++;
      $display("FAIL R%0d: hit=%b paddr=%h expected hit=%b paddr=%h", req, lk_hit, lk_paddr, eh, epa);
    end
  endtask

  task automatic cyc(input logic lv, input logic [1:0] lk, input logic [31:0] lva,
                     input logic rv, input logic [1:0] rk, input logic [31:0] rva,
                     input logic [19:0] ppn, input logic [31:0] pte,
                     input logic iv, input logic [31:0] iva);
    @(negedge clk);
    lk_valid = lv; lk_kind = lk; lk_vaddr = lva;
    rf_valid = rv; rf_kind = rk; rf_vaddr = rva; rf_ppn = ppn; rf_pte2 = pte;
    inv_valid = iv; inv_vaddr = iva;
    #1;
  endtask

  initial begin
    #1;
    cyc(1'b1, RD, 32'h00005123, 1'b0, RD, 0, 0, 0, 1'b0, 0);
    check(8, 1'b0, 32'h0);  // R8 during reset
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].op == LK, VEC[i].kind, VEC[i].va,
          VEC[i].op == RF, VEC[i].kind, VEC[i].va, VEC[i].ppn, VEC[i].pte,
          VEC[i].op == IV, VEC[i].va);
      if (VEC[i].op == LK) check(int'(VEC[i].req), VEC[i].ehit, VEC[i].epa);
    end

    // R9: refill and write lookup to the same set in one cycle
    cyc(1'b0, RD, 0, 1'b1, RD, 32'h00014000, 20'h00001, 32'h0, 1'b0, 0);
    cyc(1'b1, WR, 32'h00014000, 1'b1, RD, 32'h00054000, 20'h00002, 32'h0, 1'b0, 0);
    check(9, 1'b0, 32'h0);
    cyc(1'b1, WR, 32'h00014000, 1'b0, RD, 0, 0, 0, 1'b0, 0);
    check(9, 1'b0, 32'h0);
    cyc(1'b1, WR, 32'h00014000, 1'b0, RD, 0, 0, 0, 1'b0, 0);
    check(9, 1'b1, 32'h00001000);
    cyc(1'b1, RD, 32'h00054008, 1'b0, RD, 0, 0, 0, 1'b0, 0);
    check(9, 1'b1, 32'h00002008);

    // R10: invalidate beats refill to same set
    cyc(1'b0, RD, 0, 1'b1, RD, 32'h00015000, 20'h00003, 32'h80, 1'b1, 32'h00015000);
    cyc(1'b1, RD, 32'h00015000, 1'b0, RD, 0, 0, 0, 1'b0, 0);
    check(10, 1'b0, 32'h0);

    // R11: idle lookup on a present page
    cyc(1'b0, RD, 32'h00009010, 1'b0, RD, 0, 0, 0, 1'b0, 0);
    check(11, 1'b0, 32'h0);

    // R8: reset clears a present page
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b1, RD, 32'h00009010, 1'b0, RD, 0, 0, 0, 1'b0, 0);
    check(8, 1'b0, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule